// File: doc/BRIEF.md
# Boot Processor Failover Controller

On a board with several processors, one of them is chosen to run the startup code after power-up. This block checks that the chosen processor actually gets that code running. It runs a timeout counter on a shared timebase tick. The running code proves itself by strobing a halt input before the timeout. If the timeout ends first, the controller marks that processor as failed and drops it from the enable mask. It then emits a one-cycle failure event that carries the processor index, picks the next healthy processor and pulses the system reset so that the new choice gets its own attempt.

The cycle of timeout, disable and reset goes on until an attempt succeeds or no healthy processor is left. In the second case the controller enters desperation mode. It no longer looks at the failure marks. It enables exactly one present processor at a time, in round-robin order, and gives each one a full timeout period followed by a reset. A power-up clears the failure marks and leaves desperation mode. An external hard reset, and every reset the controller issues itself, keeps them.

Top module: `bpf_ctrl`

## Requirements
- R1: A one-cycle `por_i` captures `present_i` and clears all failure marks and desperation mode. On the next cycle the timed attempt starts on the lowest-index present processor, and `cpu_en_o` equals the captured present mask. With no processor present the block stays idle with `cpu_en_o` at zero and never times out.
- R2: `hard_rst_i` restarts the timeout count from zero for the same boot processor. Failure marks, the enable mask and desperation mode are kept.
- R3: An attempt expires on exactly the `TIMEOUT_TICKS`-th cycle with `tick_i` high counted from the start of the attempt. Ticks that arrive while the reset pulse is active are not counted.
- R4: `halt_i` during an attempt ends it as successful. After that, no failure event and no reset pulse occur until the next `por_i` or `hard_rst_i`.
- R5: On expiry, `evt_vld_o` is high for exactly one cycle, in the cycle after the expiring tick, and `evt_idx_o` holds the index of the processor that timed out.
- R6: Outside desperation mode, the processor that timed out is cleared from `cpu_en_o` in the same cycle as its event, and it stays cleared until `por_i`. In that mode `cpu_en_o` is the present mask with the failed processors removed.
- R7: The next boot processor is the first processor that is present and not failed, searching upward from the current index plus one and wrapping around.
- R8: `sys_rst_o` is high for exactly `RST_CYCLES` cycles, beginning in the event cycle. The next attempt starts with a count of zero in the cycle where `sys_rst_o` falls.
- R9: When an expiry leaves no healthy processor, `desp_o` goes high. The trial processor becomes the next present processor after the failed one, with wrap-around. `cpu_en_o` is then one-hot on the trial processor, and each later expiry advances the trial round-robin through the present processors.
- R10: `desp_o` stays high through hard resets and is cleared only by `por_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low register reset; the block idles until `por_i` |
| por_i | input | 1 | Power-up strobe; samples `present_i`, clears marks |
| hard_rst_i | input | 1 | External hard reset strobe; restarts the attempt |
| halt_i | input | 1 | Boot success strobe that stops the timer |
| tick_i | input | 1 | Timebase tick enable |
| present_i | input | N_CPU | Installed-processor mask, sampled on `por_i` |
| cpu_en_o | output | N_CPU | Processor enable mask |
| evt_vld_o | output | 1 | One-cycle failure event strobe |
| evt_idx_o | output | IDXW | Index of the processor that timed out |
| sys_rst_o | output | 1 | System reset pulse |
| desp_o | output | 1 | Desperation mode flag |

## Verification
The hardest state to reach is desperation mode with a sparse present mask. Getting there takes one full timeout and reset for every healthy processor, and the trial order then depends on where the last failure sat and where the present holes are. The bench holds the tick input high and sweeps every present mask of a four-processor setup. For each mask it lets the attempts expire more times than there are processors, so every mask crosses into desperation mode and wraps its round-robin at least once. Each event index and enable mask is predicted from a rotated-mask search written separately in the bench.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TIME = 2'd1,
    ST_RST  = 2'd2,
    ST_DONE = 2'd3
  } bpf_state_e;
endpackage

// File: rtl/bpf_timeout_ctr.sv
module bpf_timeout_ctr #(
  parameter int TIMEOUT_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == CW'(TIMEOUT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bpf_rst_pulse.sv
module bpf_rst_pulse #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic kill_i,
  output logic pulse_o,
  output logic last_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] cnt_q;

  assign pulse_o = (cnt_q != '0);
  assign last_o  = (cnt_q == RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (kill_i)     cnt_q <= '0;
    else if (start_i)    cnt_q <= RW'(RST_CYCLES);
    else if (pulse_o)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/bpf_ctrl.sv
module bpf_ctrl
  import bpf_pkg::*;
#(
  parameter int N_CPU         = 4,
  parameter int TIMEOUT_TICKS = 5000,
  parameter int RST_CYCLES    = 8,
  localparam int IDXW         = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic             hard_rst_i,
  input  logic             halt_i,
  input  logic             tick_i,
  input  logic [N_CPU-1:0] present_i,
  output logic [N_CPU-1:0] cpu_en_o,
  output logic             evt_vld_o,
  output logic [IDXW-1:0]  evt_idx_o,
  output logic             sys_rst_o,
  output logic             desp_o
);

  // Search for the first set bit of cand, starting at start and wrapping.
  // The top bit of the result says whether anything was found.
  function automatic logic [IDXW:0] pick_from(input logic [N_CPU-1:0] cand,
                                              input logic [IDXW-1:0]  start);
    logic [IDXW:0] res;
    int p;
    res = '0;
    for (int k = N_CPU - 1; k >= 0; k--) begin
      p = int'(start) + k;
      if (p >= N_CPU) p = p - N_CPU;
      if (cand[p]) res = {1'b1, IDXW'(p)};
    end
    return res;
  endfunction

  function automatic logic [IDXW-1:0] after(input logic [IDXW-1:0] idx);
    return (idx == IDXW'(N_CPU - 1)) ? '0 : idx + 1'b1;
  endfunction

  bpf_state_e       state_q;
  logic [N_CPU-1:0] pres_q, fail_q;
  logic [IDXW-1:0]  cur_q;
  logic             desp_q;

  // named internal events
  logic             timeout_hit;
  logic             fail_take;
  logic             boot_ok;
  logic             rst_last;
  logic             restart;
  logic [N_CPU-1:0] cur_oh, fail_nx;
  logic [IDXW:0]    heal_pick, rr_pick, first_pick;

  assign restart    = por_i || (hard_rst_i && state_q != ST_IDLE);
  assign boot_ok    = (state_q == ST_DONE);
  assign fail_take  = timeout_hit && !halt_i && !restart;
  assign cur_oh     = N_CPU'(1) << cur_q;
  assign fail_nx    = fail_q | cur_oh;
  assign heal_pick  = pick_from(pres_q & ~fail_nx, after(cur_q));
  assign rr_pick    = pick_from(pres_q, after(cur_q));
  assign first_pick = pick_from(present_i, '0);

  bpf_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (state_q == ST_TIME),
    .clr_i    (restart),
    .tick_i   (tick_i),
    .expire_o (timeout_hit)
  );

  bpf_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (fail_take),
    .kill_i  (restart),
    .pulse_o (sys_rst_o),
    .last_o  (rst_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pres_q    <= '0;
      fail_q    <= '0;
      cur_q     <= '0;
      desp_q    <= 1'b0;
      evt_vld_o <= 1'b0;
      evt_idx_o <= '0;
    end else begin
      evt_vld_o <= 1'b0;
      if (por_i) begin
        pres_q  <= present_i;
        fail_q  <= '0;
        desp_q  <= 1'b0;
        cur_q   <= first_pick[IDXW-1:0];
        state_q <= first_pick[IDXW] ? ST_TIME : ST_IDLE;
      end else if (restart) begin
        state_q <= ST_TIME;
      end else begin
        unique case (state_q)
          ST_TIME: begin
            if (halt_i) begin
              state_q <= ST_DONE;
            end else if (fail_take) begin
              evt_vld_o <= 1'b1;
              evt_idx_o <= cur_q;
              state_q   <= ST_RST;
              if (desp_q) begin
                cur_q <= rr_pick[IDXW-1:0];
              end else begin
                fail_q <= fail_nx;
                if (heal_pick[IDXW]) begin
                  cur_q <= heal_pick[IDXW-1:0];
                end else begin
                  desp_q <= 1'b1;
                  cur_q  <= rr_pick[IDXW-1:0];
                end
              end
            end
          end
          ST_RST:  if (rst_last) state_q <= ST_TIME;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (state_q == ST_IDLE) cpu_en_o = '0;
    else if (desp_q)        cpu_en_o = cur_oh;
    else                    cpu_en_o = pres_q & ~fail_q;
  end

  assign desp_o = desp_q;

endmodule

// File: rtl/bpf_ctrl_chk.sv
module bpf_ctrl_chk #(
  parameter int N_CPU = 4,
  parameter int IDXW  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_i,
  input logic             hard_rst_i,
  input logic [N_CPU-1:0] cpu_en_o,
  input logic             evt_vld_o,
  input logic [IDXW-1:0]  evt_idx_o,
  input logic             sys_rst_o,
  input logic             desp_o,
  input logic             timeout_hit,
  input logic             boot_ok
);
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld_o |=> !evt_vld_o); // R5
  AST_EVT_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld_o |-> $past(timeout_hit)); // R3
  AST_RST_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld_o |-> sys_rst_o); // R8
  AST_FAILED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld_o && !desp_o) |-> !cpu_en_o[evt_idx_o]); // R6
  AST_DESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    desp_o |-> ($countones(cpu_en_o) == 1)); // R9
  AST_DESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (desp_o && !por_i) |=> desp_o); // R10
  AST_QUIET_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ok && !por_i && !hard_rst_i) |=> (boot_ok && !evt_vld_o && !sys_rst_o)); // R4
endmodule

bind bpf_ctrl bpf_ctrl_chk #(.N_CPU(N_CPU), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_i       (por_i),
  .hard_rst_i  (hard_rst_i),
  .cpu_en_o    (cpu_en_o),
  .evt_vld_o   (evt_vld_o),
  .evt_idx_o   (evt_idx_o),
  .sys_rst_o   (sys_rst_o),
  .desp_o      (desp_o),
  .timeout_hit (timeout_hit),
  .boot_ok     (boot_ok)
);

// File: tb/test_bpf_ctrl.sv
module test_bpf_ctrl;
  localparam int N  = 4;
  localparam int T  = 3;
  localparam int RC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         por_i = 1'b0, hard_rst_i = 1'b0, halt_i = 1'b0, tick_i = 1'b0;
  logic [N-1:0] present_i = '0;
  logic [N-1:0] cpu_en_o;
  logic         evt_vld_o, sys_rst_o, desp_o;
  logic [1:0]   evt_idx_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bpf_ctrl #(.N_CPU(N), .TIMEOUT_TICKS(T), .RST_CYCLES(RC)) i_bpf_ctrl (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .hard_rst_i(hard_rst_i),
    .halt_i(halt_i), .tick_i(tick_i), .present_i(present_i),
    .cpu_en_o(cpu_en_o), .evt_vld_o(evt_vld_o), .evt_idx_o(evt_idx_o),
    .sys_rst_o(sys_rst_o), .desp_o(desp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // first set bit at or after start, wrapping; via a doubled, shifted mask
  function automatic int first_at(input logic [N-1:0] m, input int start);
    logic [2*N-1:0] dbl;
    dbl = {m, m} >> start;
    for (int j = 0; j < N; j++) if (dbl[j]) return (start + j) % N;
    return -1;
  endfunction

  task automatic do_por(input logic [N-1:0] m);
    present_i = m;
    por_i = 1'b1;
    step();
    por_i = 1'b0;
  endtask

  // ticks held high; returns steps until the event and the reset length
  task automatic run_attempt(output int steps, output int idx, output int rlen);
    tick_i = 1'b1;
    steps = 0;
    while (!evt_vld_o && steps < 4 * T) begin
      step();
      steps++;
    end
    idx = int'(evt_idx_o);
    rlen = 0;
    while (sys_rst_o && rlen < 20) begin
      if (rlen >= 1) chk(!evt_vld_o, "R5 strobe width", int'(evt_vld_o), 0);
      rlen++;
      step();
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int steps, idx, rlen, cur, fails;
    bit desp;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // reset state
    chk(cpu_en_o == '0, "R1 reset enables", int'(cpu_en_o), 0);
    chk(!evt_vld_o && !sys_rst_o && !desp_o, "R1 reset outputs",
        int'({evt_vld_o, sys_rst_o, desp_o}), 0);

    // empty board: idle, never times out
    do_por('0);
    chk(cpu_en_o == '0, "R1 empty enables", int'(cpu_en_o), 0);
    tick_i = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 4 * T; i++) begin
        step();
        if (evt_vld_o || sys_rst_o) seen++;
      end
      chk(seen == 0, "R1 empty no timeout", seen, 0);
    end

    // sweep every non-empty present mask through failover into desperation
    for (int pm = 1; pm < (1 << N); pm++) begin
      do_por(N'(pm));
      fails = 0;
      desp = 1'b0;
      cur = first_at(N'(pm), 0);
      chk(cpu_en_o == N'(pm), "R1 enables after power-up", int'(cpu_en_o), pm);
      chk(!desp_o, "R1 desperation cleared", int'(desp_o), 0);
      for (int a = 0; a < $countones(N'(pm)) + 3; a++) begin
        run_attempt(steps, idx, rlen);
        chk(steps == T, "R3 timeout length", steps, T);
        chk(idx == cur, desp ? "R9 trial index" : "R7 boot index", idx, cur);
        chk(rlen == RC, "R8 reset width", rlen, RC);
        if (!desp) begin
          fails = fails | (1 << cur);
          if ((pm & ~fails) != 0) cur = first_at(N'(pm & ~fails), (cur + 1) % N);
          else begin
            desp = 1'b1;
            cur = first_at(N'(pm), (cur + 1) % N);
          end
        end else begin
          cur = first_at(N'(pm), (cur + 1) % N);
        end
        chk(desp_o == desp, "R9 desperation flag", int'(desp_o), int'(desp));
        if (desp) chk(cpu_en_o == N'(1 << cur), "R9 one-hot enable", int'(cpu_en_o), 1 << cur);
        else      chk(cpu_en_o == N'(pm & ~fails), "R6 failed removed", int'(cpu_en_o), pm & ~fails);
      end
    end

    // hard reset keeps marks and restarts the count
    do_por(4'b1111);
    run_attempt(steps, idx, rlen);
    run_attempt(steps, idx, rlen);
    tick_i = 1'b1;
    repeat (T - 1) step();
    tick_i = 1'b0;
    hard_rst_i = 1'b1;
    step();
    hard_rst_i = 1'b0;
    chk(cpu_en_o == 4'b1100, "R2 marks kept", int'(cpu_en_o), 12);
    run_attempt(steps, idx, rlen);
    chk(steps == T, "R2 count restarted", steps, T);
    chk(idx == 2, "R2 same boot processor", idx, 2);

    // halt ends the attempt: nothing follows
    do_por(4'b1111);
    tick_i = 1'b1;
    repeat (T - 1) step();
    halt_i = 1'b1;
    step();
    halt_i = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 4 * T; i++) begin
        step();
        if (evt_vld_o || sys_rst_o) seen++;
      end
      chk(seen == 0, "R4 quiet after halt", seen, 0);
    end
    chk(cpu_en_o == 4'b1111, "R4 enables unchanged", int'(cpu_en_o), 15);

    // desperation survives hard reset, power-up clears it
    do_por(4'b0101);
    run_attempt(steps, idx, rlen);
    run_attempt(steps, idx, rlen);
    chk(desp_o, "R9 desperation entered", int'(desp_o), 1);
    chk(cpu_en_o == 4'b0001, "R9 trial after wrap", int'(cpu_en_o), 1);
    hard_rst_i = 1'b1;
    step();
    hard_rst_i = 1'b0;
    chk(desp_o, "R10 kept over hard reset", int'(desp_o), 1);
    do_por(4'b0101);
    chk(!desp_o, "R10 cleared by power-up", int'(desp_o), 0);
    chk(cpu_en_o == 4'b0101, "R10 marks cleared", int'(cpu_en_o), 5);

    tick_i = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule